// File: doc/BRIEF.md
# Event channel status and interrupt flags

This block keeps the status of eight event-routing channels and turns it into one interrupt request. Each channel receives an event-valid pulse, a mode bit that puts it on the synchronous or the asynchronous path, and three per-user vectors: which users are connected, which are ready, and which acknowledge the event they were handed. For each channel the block holds an event-detected flag and an overrun flag. Software reads both through one 32-bit status word and clears them by writing ones.

Every channel is a small state machine with two states. `CH_IDLE` means no user still owes an acknowledge. `CH_WAIT` means the pending-user mask is nonzero. The transitions are:
- `CH_IDLE -> CH_WAIT`: an accepted event with at least one connected user.
- `CH_WAIT -> CH_WAIT`: a new accepted event (an overrun), or acknowledges that leave some bits pending.
- `CH_WAIT -> CH_IDLE`: the last pending user acknowledges.
- any state `-> CH_IDLE`: the asynchronous mode bit is set.

A flag bank gathers the set pulses of all channels, applies software clears and produces the registered read data and the registered interrupt.

Top module: `evch_flag_ctrl`

## Requirements
- R1: After reset all flags are zero, `reg_rdata` reads 0 and `irq` is low.
- R2: Status bit 8+c is the event-detected flag of channel c and bit c is its overrun flag (c = 0..7). Bits 31:16 read as zero, and writing them has no effect.
- R3: An event on a channel on the synchronous path sets its event-detected flag at the clock edge that samples the event. `reg_rdata` shows the new flag value one clock later.
- R4: An accepted event sets the overrun flag when any user that is connected to the channel is not ready. Users that are not connected are ignored.
- R5: An accepted event also sets the overrun flag when the channel's pending-user mask is nonzero, meaning the previous event has not been acknowledged by every user.
- R6: An accepted event loads the pending-user mask with the connected-user vector. An acknowledge clears the matching mask bit. Once the mask is empty, a new event with all connected users ready raises no overrun.
- R7: While a channel's mode bit selects the asynchronous path (1), neither of its flags is set and its pending-user mask is emptied.
- R8: A write with a one in bit k (k = 0..15) clears flag k. A zero in bit k leaves flag k unchanged.
- R9: When a hardware set and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is the registered OR of `flags & irq_en`, where `irq_en` bit k enables status bit k. It falls one clock after the last enabled set flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 8 | Event pulse, one bit per channel |
| async_mode | input | 8 | 1 = channel uses the asynchronous path |
| user_conn | input | 32 | Connected users, 4 bits per channel (channel c at bits 4c+3:4c) |
| user_ready | input | 32 | Ready state of each user, same packing |
| user_ack | input | 32 | Acknowledge pulse of each user, same packing |
| reg_we | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Write data, ones clear flags |
| irq_en | input | 16 | Interrupt enable, one bit per status flag |
| reg_rdata | output | 32 | Registered status read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties check several rules on every cycle:
- the channel state agrees with its pending mask;
- an accepted event in `CH_WAIT` always flags an overrun;
- the asynchronous mode never produces a set pulse and forces `CH_IDLE`;
- a set always survives into the flag register, and write-one clears and write-zero keeps hold bit by bit.

The bench scenarios are needed for the things the properties do not cover:
- the mapping of each channel onto its status bits;
- the one-cycle read-data lag and the fall time of `irq`;
- the fact that unconnected users never cause an overrun;
- the full sweep of connected and ready patterns, which shows the overrun decision as a whole.

// File: rtl/evch_pkg.sv
package evch_pkg;
    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_WAIT = 1'b1
    } ch_state_e;
endpackage

// File: rtl/evch_channel.sv
module evch_channel
    import evch_pkg::*;
#(
    parameter int NUM_USERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_i,
    input  logic                 async_i,
    input  logic [NUM_USERS-1:0] conn_i,
    input  logic [NUM_USERS-1:0] ready_i,
    input  logic [NUM_USERS-1:0] ack_i,
    output logic                 evd_set_o,
    output logic                 ovr_set_o
);
    ch_state_e              state_q, state_d;
    logic [NUM_USERS-1:0]   mask_q, mask_d;
    logic                   accept;
    logic                   busy_users;

    assign accept     = evt_i && !async_i;
    assign busy_users = |(conn_i & ~ready_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q & ~ack_i;
        unique case (state_q)
            CH_IDLE: begin
                if (accept) begin
                    mask_d  = conn_i;
                    state_d = (|conn_i) ? CH_WAIT : CH_IDLE;
                end
            end
            CH_WAIT: begin
                if (accept) begin
                    mask_d  = conn_i;
                    state_d = (|conn_i) ? CH_WAIT : CH_IDLE;
                end else if (mask_d == '0) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
        if (async_i) begin
            mask_d  = '0;
            state_d = CH_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    // outputs
    always_comb begin
        evd_set_o = 1'b0;
        ovr_set_o = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                evd_set_o = accept;
                ovr_set_o = accept && busy_users;
            end
            CH_WAIT: begin
                evd_set_o = accept;
                ovr_set_o = accept;
            end
            default: ;
        endcase
    end

    AST_STATE_HAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_WAIT) |-> (mask_q != '0));                      // R6
    AST_MASK_HAS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0) |-> (state_q == CH_WAIT));                      // R6
    AST_PENDING_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_WAIT && evt_i && !async_i) |-> ovr_set_o);      // R5
    AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        async_i |-> (!evd_set_o && !ovr_set_o));                        // R7
    AST_ASYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        async_i |=> (state_q == CH_IDLE));                              // R7
endmodule

// File: rtl/evch_flag_bank.sv
module evch_flag_bank #(
    parameter int NUM_CH   = 8,
    parameter int STATUS_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     evd_set_i,
    input  logic [NUM_CH-1:0]     ovr_set_i,
    input  logic                  we_i,
    input  logic [STATUS_W-1:0]   wdata_i,
    input  logic [2*NUM_CH-1:0]   irq_en_i,
    output logic [STATUS_W-1:0]   rdata_o,
    output logic                  irq_o
);
    localparam int FLAG_W = 2 * NUM_CH;

    logic [FLAG_W-1:0]   flags_q, flags_d;
    logic [FLAG_W-1:0]   set_vec;
    logic [FLAG_W-1:0]   clr_vec;
    logic [STATUS_W-1:0] rdata_q;
    logic                irq_q;

    assign set_vec = {evd_set_i, ovr_set_i};
    assign clr_vec = we_i ? wdata_i[FLAG_W-1:0] : '0;
    assign flags_d = (flags_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            rdata_q <= STATUS_W'(flags_q);
            irq_q   <= |(flags_q & irq_en_i);
        end
    end

    assign rdata_o = rdata_q;
    assign irq_o   = irq_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));       // R9
    AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((flags_q & $past(clr_vec & ~set_vec)) == '0));                   // R8
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q != '0) |=> ((flags_q & $past(flags_q & ~clr_vec)) == $past(flags_q & ~clr_vec))); // R8
endmodule

// File: rtl/evch_flag_ctrl.sv
module evch_flag_ctrl #(
    parameter int NUM_CH    = 8,
    parameter int NUM_USERS = 4,
    parameter int STATUS_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           evt_valid,
    input  logic [NUM_CH-1:0]           async_mode,
    input  logic [NUM_CH*NUM_USERS-1:0] user_conn,
    input  logic [NUM_CH*NUM_USERS-1:0] user_ready,
    input  logic [NUM_CH*NUM_USERS-1:0] user_ack,
    input  logic                        reg_we,
    input  logic [STATUS_W-1:0]         reg_wdata,
    input  logic [2*NUM_CH-1:0]         irq_en,
    output logic [STATUS_W-1:0]         reg_rdata,
    output logic                        irq
);
    logic [NUM_CH-1:0] evd_set;
    logic [NUM_CH-1:0] ovr_set;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        evch_channel #(
            .NUM_USERS (NUM_USERS)
        ) i_channel (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_valid[c]),
            .async_i   (async_mode[c]),
            .conn_i    (user_conn[c*NUM_USERS +: NUM_USERS]),
            .ready_i   (user_ready[c*NUM_USERS +: NUM_USERS]),
            .ack_i     (user_ack[c*NUM_USERS +: NUM_USERS]),
            .evd_set_o (evd_set[c]),
            .ovr_set_o (ovr_set[c])
        );
    end

    evch_flag_bank #(
        .NUM_CH   (NUM_CH),
        .STATUS_W (STATUS_W)
    ) i_flag_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evd_set_i (evd_set),
        .ovr_set_i (ovr_set),
        .we_i      (reg_we),
        .wdata_i   (reg_wdata),
        .irq_en_i  (irq_en),
        .rdata_o   (reg_rdata),
        .irq_o     (irq)
    );
endmodule

// File: tb/test_evch_flag_ctrl.sv
module test_evch_flag_ctrl;
    localparam int NC = 8;
    localparam int NU = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] d_evt = '0, d_async = '0;
    logic [31:0]   d_conn = '0, d_ready = '1, d_ack = '0;
    logic          d_we = 1'b0;
    logic [31:0]   d_wdata = '0;
    logic [15:0]   d_en = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    // bench model, built from the requirements
    logic [15:0]   m_flags = '0;
    logic [31:0]   m_rdata = '0;
    logic          m_irq = 1'b0;
    logic [NU-1:0] m_mask [NC];

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    evch_flag_ctrl i_evch_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_valid(d_evt), .async_mode(d_async),
        .user_conn(d_conn), .user_ready(d_ready), .user_ack(d_ack),
        .reg_we(d_we), .reg_wdata(d_wdata), .irq_en(d_en),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: model update at the edge, then return at the falling edge
    task automatic tick();
        logic [15:0]   setv;
        logic [NU-1:0] cn, rd, ak;
        setv = '0;
        @(posedge clk);
        for (int c = 0; c < NC; c++) begin
            cn = d_conn[c*NU +: NU];
            rd = d_ready[c*NU +: NU];
            ak = d_ack[c*NU +: NU];
            if (d_async[c]) begin
                m_mask[c] = '0;
            end else if (d_evt[c]) begin
                setv[8+c] = 1'b1;
                if (m_mask[c] != '0 || (cn & ~rd) != '0) setv[c] = 1'b1;
                m_mask[c] = cn;
            end else begin
                m_mask[c] = m_mask[c] & ~ak;
            end
        end
        m_rdata = {16'h0, m_flags};
        m_irq   = |(m_flags & d_en);
        m_flags = (m_flags & ~(d_we ? d_wdata[15:0] : 16'h0)) | setv;
        @(negedge clk);
    endtask

    task automatic settle(input string req);
        d_evt = '0; d_ack = '0; d_we = 1'b0;
        tick();
        tick();
        chk(req, reg_rdata, m_rdata);
        chk(req, {31'h0, irq}, {31'h0, m_irq});
    endtask

    task automatic clean();
        d_evt = '0; d_ack = '1; d_we = 1'b1; d_wdata = 32'h0000FFFF;
        tick();
        d_ack = '0; d_we = 1'b0; d_wdata = '0;
        tick();
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) m_mask[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", reg_rdata, 32'h0);
        chk("R1", {31'h0, irq}, 32'h0);

        // R3, R4: every channel, every ready pattern, all users connected
        d_conn = '1;
        for (int c = 0; c < NC; c++) begin
            for (int r = 0; r < 16; r++) begin
                d_ready = '1;
                d_ready[c*NU +: NU] = 4'(r);
                d_evt = '0; d_evt[c] = 1'b1;
                tick();
                d_evt = '0;
                tick();
                chk("R3", reg_rdata, 32'h1 << (8 + c) | ((r != 15) ? (32'h1 << c) : 32'h0));
                d_ready = '1;
                clean();
            end
        end

        // R4, R6: connected and ready sweep on channel 3
        for (int cn = 0; cn < 16; cn++) begin
            for (int r = 0; r < 16; r++) begin
                d_conn[12 +: 4] = 4'(cn);
                d_ready[12 +: 4] = 4'(r);
                d_evt = 8'h08;
                tick();
                d_evt = '0;
                tick();
                chk("R4", reg_rdata, 32'h0800 | (((cn & ~r & 15) != 0) ? 32'h8 : 32'h0));
                d_ready = '1;
                clean();
            end
        end
        d_conn = '1;

        // R5, R6: partial acknowledge, then full acknowledge
        d_evt = 8'h04; tick();
        d_evt = '0; d_ack[8 +: 4] = 4'h3; tick();
        d_ack = '0; d_evt = 8'h04; tick();
        d_evt = '0; tick();
        chk("R5", reg_rdata, 32'h0404);
        clean();
        d_evt = 8'h04; tick();
        d_evt = '0; d_ack[8 +: 4] = 4'hF; tick();
        d_ack = '0; d_evt = 8'h04; tick();
        d_evt = '0; tick();
        chk("R6", reg_rdata, 32'h0400);
        d_ack = '1; clean();

        // R7: asynchronous channels never flag, and the pending mask is dropped
        for (int c = 0; c < NC; c++) begin
            d_async = '0; d_async[c] = 1'b1;
            d_ready = '0;
            d_evt = '0; d_evt[c] = 1'b1;
            tick();
            settle("R7");
            chk("R7", reg_rdata, 32'h0);
        end
        d_async = '0; d_ready = '1;
        d_evt = 8'h20; tick();
        d_evt = '0; d_async = 8'h20; tick();
        d_async = '0; d_evt = 8'h20; tick();
        d_evt = '0; tick();
        chk("R7", reg_rdata, 32'h2000);
        clean();

        // R2, R8: reserved writes, write-one clears, write-zero keeps
        d_ready = '0; d_evt = '1; tick();
        d_evt = '0; d_ack = '1; tick();
        d_ack = '0; d_we = 1'b1; d_wdata = 32'hFFFF_0000; tick();
        d_we = 1'b0; tick();
        chk("R2", reg_rdata, 32'h0000FFFF);
        d_we = 1'b1; d_wdata = 32'h0000_0000; tick();
        settle("R8");
        chk("R8", reg_rdata, 32'h0000FFFF);
        d_we = 1'b1; d_wdata = 32'h0000_00FF; tick();
        settle("R8");
        chk("R8", reg_rdata, 32'h0000FF00);
        d_ready = '1; clean();

        // R9: set and clear of the same flag in one cycle
        d_evt = 8'h02; d_we = 1'b1; d_wdata = 32'h0000_0200; tick();
        settle("R9");
        chk("R9", reg_rdata, 32'h0000_0200);

        // R10: enable mapping and fall timing
        d_en = 16'h0200; tick();
        chk("R10", {31'h0, irq}, 32'h1);
        d_en = 16'hFDFF; tick();
        tick();
        chk("R10", {31'h0, irq}, 32'h0);
        d_en = 16'h0200; tick(); tick();
        chk("R10", {31'h0, irq}, 32'h1);
        d_ack = '1; d_we = 1'b1; d_wdata = 32'h0000_0200; tick();
        d_ack = '0; d_we = 1'b0;
        chk("R10", {31'h0, irq}, 32'h1);
        tick();
        chk("R10", {31'h0, irq}, 32'h0);
        chk("R10", reg_rdata, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule